// File: doc/BRIEF.md
# Auto-Reload 16-bit Timer and Event Counter

This block is a 16-bit up-counter with a reload register. Software reaches it through a byte-wide register port. It counts in one of two ways. As a timer it advances once every four system clocks. As an event counter it advances once per rising edge of an external input. The edges from that input are first synchronised and then edge-detected. When the count passes its all-ones value, the counter reloads the value held in the reload register and keeps running. Each such overflow raises a sticky request flag. The flag reaches the interrupt line only while the interrupt enable is high.

Because the bus is byte-wide, the 16-bit values are moved in two steps. A low-byte write is held in a holding buffer. It takes effect only when the high byte is written, and then both bytes land in the reload register in one cycle. If the counter is stopped, that same high-byte write also places the new value in the counter. Reads work the other way round. Reading the low byte captures the upper byte at that moment, so a later high-byte read returns a value consistent with the low byte already read.

Register map (bus_addr): 0 is the count low byte, 1 is the count high byte, 2 is control.

Control byte fields:
- bits [7:6]: mode.
- bit 4: run.
- bit 0: overflow flag. It reads back the flag. Writing 0 here clears the flag; writing 1 has no effect.
- All other bits read as 0.

Top module: `reload_timer16`

## Requirements
- R1: After synchronous reset the count is 0x0000, the reload value is 0x0000, control reads 0x00 and irq_req is 0.
- R2: A write to address 0 changes neither the count nor the reload value; the byte waits in the holding buffer.
- R3: A write to address 1 sets the reload value to {written byte, buffered low byte}. While run (control bit 4) is 0, the same write also loads that value into the count. While run is 1, the count is left alone.
- R4: With run=1 and mode 2'b10 (timer), the count rises by exactly one every 4 clocks, with the first step 4 clocks after the enabling write.
- R5: With run=1 and mode 2'b01 (event), each rising edge of evt_in adds exactly one to the count, no matter how long the input stays high. The new count is visible three clocks after the edge.
- R6: With run=0, or with mode 2'b00 or 2'b11, the count holds its value whatever evt_in and time do.
- R7: A step taken from 0xFFFF loads the reload value into the count instead of wrapping to zero.
- R8: Every overflow sets control bit 0, and irq_req equals that flag ANDed with irq_en.
- R9: The flag stays set until a control write with bit 0 equal to 0 or a one-cycle irq_ack pulse clears it. A control write with bit 0 equal to 1 leaves it set.
- R10: Reading address 0 returns the count low byte and captures the count high byte. Reading address 1 returns the captured byte, not the live one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe; a read of address 0 captures the high byte |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| evt_in | input | 1 | External event input, asynchronous |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| irq_ack | input | 1 | Acknowledge pulse that clears the overflow flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Most wrong internal states reach the ports quickly. A bad divider phase or a missing synchroniser stage moves the count read back by one within four clocks of enabling. A wrong reload value shows only at the first overflow, as a count that jumps to the wrong place. A flag that fails to set or clear is seen on irq_req and control bit 0 in the very next cycle. The bench sweeps start values and step counts, and computes each expected count arithmetically. It also drives both overflow paths, so a corrupted holding buffer or capture register shows up as a mismatched byte on the next read.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_RSVD  = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      run;
    } tmr_ctrl_t;

    // control byte layout: mode [7:6], run [4], flag [0]
    function automatic logic [BYTE_W-1:0] ctrl_to_byte(tmr_ctrl_t c, logic flag);
        return {c.mode, 1'b0, c.run, 3'b000, flag};
    endfunction

    function automatic tmr_ctrl_t byte_to_ctrl(logic [BYTE_W-1:0] b);
        tmr_ctrl_t c;
        c.mode = tmr_mode_e'(b[7:6]);
        c.run  = b[4];
        return c;
    endfunction

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            assign tick = enable;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || !enable) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end

            assign tick = enable && (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/tmr16_evsync.sv
module tmr16_evsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], raw_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] preload,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    assign wrap = step && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (wrap) begin
            count <= preload;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic              ctrl_wr,
    input  logic              lo_rd,
    input  tmr_reg_e          rsel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [W-1:0]      count,
    input  logic              wrap,
    input  logic              irq_ack,
    output logic [BYTE_W-1:0] rdata,
    output tmr_ctrl_t         ctrl,
    output logic [W-1:0]      preload,
    output logic              load_en,
    output logic [W-1:0]      load_val,
    output logic              flag
);
    localparam int HI_W = W - BYTE_W;

    logic [BYTE_W-1:0] lo_hold;
    logic [HI_W-1:0]   hi_snap;
    logic              unused_ctrl_bits;

    assign unused_ctrl_bits = ^{wdata[5], wdata[3:1]};
    assign load_val = {wdata[HI_W-1:0], lo_hold};
    assign load_en  = hi_wr && !ctrl.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold <= '0;
            hi_snap <= '0;
            preload <= '0;
            ctrl    <= '{mode: MODE_OFF, run: 1'b0};
            flag    <= 1'b0;
        end else begin
            if (lo_wr) lo_hold <= wdata;
            if (hi_wr) preload <= load_val;
            if (lo_rd) hi_snap <= count[W-1:BYTE_W];
            if (ctrl_wr) ctrl <= byte_to_ctrl(wdata);
            if (wrap) begin
                flag <= 1'b1;
            end else if (irq_ack || (ctrl_wr && !wdata[0])) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rsel)
            REG_CNT_LO: rdata = count[BYTE_W-1:0];
            REG_CNT_HI: rdata = BYTE_W'(hi_snap);
            REG_CTRL:   rdata = ctrl_to_byte(ctrl, flag);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
    import tmr16_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int CLK_DIV   = 4,
    parameter int SYNC_FFS  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       evt_in,
    input  logic       irq_en,
    input  logic       irq_ack,
    output logic       irq_req
);
    tmr_reg_e         rsel;
    tmr_ctrl_t        ctrl;
    tmr_mode_e        mode_q;
    logic             run_on;
    logic             lo_wr, hi_wr, ctrl_wr, lo_rd;
    logic             ptick, erise, step, wrap, flag, load_en;
    logic [CNT_W-1:0] count, preload, load_val;

    assign rsel    = tmr_reg_e'(bus_addr);
    assign lo_wr   = bus_wr && (rsel == REG_CNT_LO);
    assign hi_wr   = bus_wr && (rsel == REG_CNT_HI);
    assign ctrl_wr = bus_wr && (rsel == REG_CTRL);
    assign lo_rd   = bus_rd && (rsel == REG_CNT_LO);
    assign run_on  = ctrl.run;
    assign mode_q  = ctrl.mode;

    tmr16_prescale #(.DIV(CLK_DIV)) u_pre (
        .clk(clk), .rst(rst),
        .enable(run_on && (mode_q == MODE_TIMER)),
        .tick(ptick)
    );

    tmr16_evsync #(.STAGES(SYNC_FFS)) u_sync (
        .clk(clk), .rst(rst), .raw_in(evt_in), .rise(erise)
    );

    assign step = run_on && (((mode_q == MODE_TIMER) && ptick) ||
                             ((mode_q == MODE_EVENT) && erise));

    tmr16_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .lo_wr(lo_wr), .hi_wr(hi_wr), .ctrl_wr(ctrl_wr), .lo_rd(lo_rd),
        .rsel(rsel), .wdata(bus_wdata), .count(count), .wrap(wrap),
        .irq_ack(irq_ack), .rdata(bus_rdata), .ctrl(ctrl),
        .preload(preload), .load_en(load_en), .load_val(load_val),
        .flag(flag)
    );

    tmr16_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .step(step), .load_en(load_en),
        .load_val(load_val), .preload(preload),
        .count(count), .wrap(wrap)
    );

    assign irq_req = flag & irq_en;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
    import tmr16_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         step,
    input logic         wrap,
    input logic         run_on,
    input logic         lo_wr,
    input logic         hi_wr,
    input logic         flag,
    input logic         irq_req,
    input tmr_mode_e    mode_q,
    input logic [W-1:0] count,
    input logic [W-1:0] preload
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !flag && !irq_req && preload == '0));

    // R2
    lo_buffered_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_wr && !hi_wr) |=> $stable(preload));

    // R4
    timer_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode_q == MODE_TIMER) |=> !(step && mode_q == MODE_TIMER));

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_on && !hi_wr) |=> $stable(count));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == $past(preload)));

    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(wrap));
endmodule

bind reload_timer16 tmr16_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .step(step), .wrap(wrap), .run_on(run_on),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .flag(flag), .irq_req(irq_req),
    .mode_q(mode_q), .count(count), .preload(preload)
);

// File: tb/sim_reload_timer16.sv
`timescale 1ns/1ps
module sim_reload_timer16;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       evt_in = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
    logic       irq_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    reload_timer16 u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq_en(irq_en), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start just after a falling edge and end on one
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_count(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd_reg(2'd0, lo);
        rd_reg(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic load_stopped(input logic [15:0] v);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd0, v[7:0]);
        wr_reg(2'd1, v[15:8]);
    endtask

    task automatic pulse_evt(input int high_cycles);
        evt_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        evt_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int          acc;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(2'd2, b);     check("R1 ctrl", b, 8'h00);
        rd_count(v);         check("R1 count", v, 16'h0000);
        check("R1 irq_req", irq_req, 0);

        // R2 low write is buffered only
        wr_reg(2'd0, 8'h34);
        rd_count(v);         check("R2 count untouched", v, 16'h0000);
        // R3 high write while stopped loads the count
        wr_reg(2'd1, 8'h12);
        rd_count(v);         check("R3 stopped load", v, 16'h1234);

        // R10 captured high byte
        rd_reg(2'd0, b);     check("R10 low", b, 8'h34);
        wr_reg(2'd0, 8'h66);
        wr_reg(2'd1, 8'h55);
        rd_reg(2'd1, b);     check("R10 captured high", b, 8'h12);
        rd_count(v);         check("R10 new count", v, 16'h5566);

        // R4 timer sweep
        for (int n = 1; n <= 8; n++) begin
            logic [15:0] base;
            base = 16'(n * 16'h0111 + 16'h00F0);
            load_stopped(base);
            wr_reg(2'd2, 8'h90);
            idle(4 * n);
            rd_count(v);
            check("R4 timer count", v, 16'(base + n));
            wr_reg(2'd2, 8'h00);
            idle(30);
            rd_count(v);
            check("R6 stopped hold", v, 16'(base + n));
        end

        // R6 idle mode codes
        load_stopped(16'h0100);
        wr_reg(2'd2, 8'h10);
        pulse_evt(3); idle(20);
        rd_count(v);         check("R6 mode 00 hold", v, 16'h0100);
        wr_reg(2'd2, 8'hD0);
        pulse_evt(3); idle(20);
        rd_count(v);         check("R6 mode 11 hold", v, 16'h0100);

        // R5 event counting
        load_stopped(16'h0020);
        wr_reg(2'd2, 8'h50);
        acc = 16'h0020;
        for (int k = 1; k <= 5; k++) begin
            for (int p = 0; p < k; p++) pulse_evt(1 + p);
            acc += k;
            idle(2);
            rd_count(v);
            check("R5 event count", v, acc);
        end
        pulse_evt(12); idle(2);
        rd_count(v);         check("R5 long level once", v, acc + 1);

        // R7 / R8 / R9 event overflow
        load_stopped(16'hFFFE);
        wr_reg(2'd2, 8'h50);
        wr_reg(2'd0, 8'h34);
        wr_reg(2'd1, 8'h12);
        rd_count(v);         check("R3 running no load", v, 16'hFFFE);
        pulse_evt(1); idle(2);
        rd_reg(2'd2, b);     check("R8 no flag yet", b, 8'h50);
        pulse_evt(1); idle(2);
        rd_count(v);         check("R7 reload", v, 16'h1234);
        rd_reg(2'd2, b);     check("R8 flag set", b, 8'h51);
        check("R8 irq masked", irq_req, 0);
        irq_en = 1'b1; #1;
        check("R8 irq enabled", irq_req, 1);
        @(negedge clk);
        wr_reg(2'd2, 8'h51);
        rd_reg(2'd2, b);     check("R9 write one keeps", b, 8'h51);
        wr_reg(2'd2, 8'h50);
        rd_reg(2'd2, b);     check("R9 write zero clears", b, 8'h50);
        check("R9 irq low", irq_req, 0);

        // R7 / R9 timer overflow, cleared by irq_ack
        load_stopped(16'hFFFD);
        wr_reg(2'd2, 8'h90);
        idle(12);
        rd_count(v);         check("R7 timer reload", v, 16'hFFFD);
        rd_reg(2'd2, b);     check("R8 timer flag", b, 8'h91);
        check("R8 irq high", irq_req, 1);
        irq_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_ack = 1'b0;
        rd_reg(2'd2, b);     check("R9 ack clears", b, 8'h90);
        check("R9 irq cleared", irq_req, 0);
        wr_reg(2'd2, 8'h00);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule